// File: doc/BRIEF.md
# Raster Display Controller Run Control and Event Status

This block holds the run/stop control and the event status of a raster display controller. Software programs it through a small synchronous register port. The control word carries:

- a run bit;
- a two-bit load-mode field, which tells the fetch engine what to load;
- one interrupt enable per status source.

The status word collects single-cycle event pulses from the timing core and the fetch engine into sticky bits. A single interrupt line is raised whenever an enabled status bit is set.

Stopping is graceful. When software clears the run bit, the controller keeps driving the panel until the timing core reports the end of the current frame. Only then does it go idle and raise the done status.

Each status bit has its own clearing rule:

- Informational bits are cleared by writing 1 to them.
- Error bits can only be cleared by stopping the controller.
- The done bit holds until the controller is started again.

Top module: `raster_ctl_status`

## Requirements
- R1: After reset, the control word and the status word both read 0, and `irq` and `lcd_on` are 0.
- R2: The control word stores the run bit at bit 0, the interrupt enables at bits 14:8 (enable bit 8+k gates status bit k), and the load mode at bits 21:20 (01 palette only, 10 frame only, 00 both). All other bits read 0. `load_sel` always shows bits 21:20.
- R3: While idle, storing a 1 in the run bit raises `lcd_on` on the next clock edge and clears the done bit on that same edge.
- R4: After the run bit is cleared, `lcd_on` stays 1 until an `evt_frame_end` pulse arrives. On the edge that samples that pulse, `lcd_on` falls and status bit 0 (done) sets.
- R5: The status bits are: 0 done, 1 vsync, 2 line, 3 AC-bias count, 4 palette loaded, 5 sync lost, 6 FIFO underflow. A pulse on an event input sets its bit on the edge that samples it, but only while `lcd_on` is 1. While idle, event pulses are ignored.
- R6: Writing 1 to status bit 1, 2 or 3 clears it, and writing 0 leaves it unchanged. If an event pulse and a clearing write reach the same bit in the same cycle, the bit stays set.
- R7: Writing 1 to status bit 4 clears it only when the load mode is 01. In any other mode that write is ignored, and the bit is cleared when the controller leaves the running state.
- R8: Status bits 5 and 6 ignore writes. They are cleared on the edge where the controller leaves the running state after the run bit is cleared.
- R9: The done bit ignores writes and stays set until the controller is started again.
- R10: `irq` is 1 exactly when some status bit k and control bit 8+k are both 1.
- R11: While `lcd_on` is 1, a control write whose run bit is 0 cannot clear the done interrupt enable (bit 8). A set enable reads back 1.
- R12: A read returns data on `rd_data` one clock edge after `rd_en` is sampled. The control word is at address 0 and the status word at address 4. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, registered |
| evt_frame_end | input | 1 | End-of-frame pulse from the timing core |
| evt_vsync | input | 1 | Vertical sync pulse |
| evt_line | input | 1 | Line-match pulse |
| evt_acb | input | 1 | AC-bias count pulse |
| evt_pal_loaded | input | 1 | Palette load finished pulse from the fetch engine |
| evt_sync_lost | input | 1 | Sync-lost error pulse |
| evt_underflow | input | 1 | FIFO underflow error pulse |
| irq | output | 1 | Interrupt request |
| lcd_on | output | 1 | Controller is running or finishing its last frame |
| load_sel | output | 2 | Load mode presented to the fetch engine |

## Verification
The bench builds the block with its default parameters. These are a 4-bit byte address with the control word at 0 and the status word at 4, a 32-bit data path, the enables starting at bit 8 and the mode field at bit 20.

With these values, address 8 is an unmapped location inside the address space, so the zero read-back can be reached. A write of all ones into the control word shows that the unused bits hold no storage.

The stop sequence is exercised in both the frame-only and the palette-only modes. This is where the clearing rules of the palette-loaded bit differ.

// File: rtl/raster_ctl_pkg.sv
package raster_ctl_pkg;

  localparam int NSTAT = 7;

  localparam int B_DONE  = 0;
  localparam int B_VSYNC = 1;
  localparam int B_LINE  = 2;
  localparam int B_ACB   = 3;
  localparam int B_PAL   = 4;
  localparam int B_SYNC  = 5;
  localparam int B_UFLOW = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2
  } run_st_e;

  localparam logic [1:0] LM_BOTH  = 2'b00;
  localparam logic [1:0] LM_PAL   = 2'b01;
  localparam logic [1:0] LM_FRAME = 2'b10;

  // Status bit idx may be cleared by a write of 1 in load mode md.
  function automatic logic w1c_ok(int idx, logic [1:0] md);
    case (idx)
      B_VSYNC, B_LINE, B_ACB: return 1'b1;
      B_PAL:                  return md == LM_PAL;
      default:                return 1'b0;
    endcase
  endfunction

  // Status bit idx is cleared when the controller leaves the running state.
  function automatic logic clr_on_stop(int idx, logic [1:0] md);
    case (idx)
      B_SYNC, B_UFLOW: return 1'b1;
      B_PAL:           return md != LM_PAL;
      default:         return 1'b0;
    endcase
  endfunction

  // Status bit idx is cleared when the controller starts.
  function automatic logic clr_on_start(int idx);
    return idx == B_DONE;
  endfunction

  function automatic logic irq_of(logic [NSTAT-1:0] st, logic [NSTAT-1:0] en);
    return |(st & en);
  endfunction

endpackage

// File: rtl/raster_ctl_regs.sv
module raster_ctl_regs
  import raster_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_run,
  input  logic [NSTAT-1:0] wr_ien,
  input  logic [1:0]       wr_mode,
  input  logic             lcd_on,
  output logic             ctrl_en,
  output logic [NSTAT-1:0] ctrl_ien,
  output logic [1:0]       ctrl_mode
);

  // The done enable survives a stop request while frames are still out.
  logic keep_done_en;
  assign keep_done_en = lcd_on && !wr_run && ctrl_ien[B_DONE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_ien  <= '0;
      ctrl_mode <= LM_BOTH;
    end else if (wr_ctrl) begin
      ctrl_en   <= wr_run;
      ctrl_mode <= wr_mode;
      ctrl_ien  <= {wr_ien[NSTAT-1:1], wr_ien[B_DONE] | keep_done_en};
    end
  end

endmodule

// File: rtl/raster_run_fsm.sv
module raster_run_fsm
  import raster_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_en,
  input  logic evt_frame_end,
  output logic lcd_on,
  output logic stopping,
  output logic start_p,
  output logic stop_req_p,
  output logic stop_done_p
);

  run_st_e st_q, st_d;

  assign start_p     = (st_q == ST_IDLE) && ctrl_en;
  assign stop_req_p  = (st_q == ST_RUN) && !ctrl_en;
  assign stop_done_p = (st_q == ST_STOP) && evt_frame_end;
  assign lcd_on      = st_q != ST_IDLE;
  assign stopping    = st_q == ST_STOP;

  always_comb begin
    st_d = st_q;
    if (start_p)     st_d = ST_RUN;
    if (stop_req_p)  st_d = ST_STOP;
    if (stop_done_p) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/raster_stat_bank.sv
module raster_stat_bank
  import raster_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] evt,
  input  logic             active,
  input  logic             wr_stat,
  input  logic [NSTAT-1:0] wr_bits,
  input  logic [1:0]       mode,
  input  logic             start_p,
  input  logic             stop_req_p,
  output logic [NSTAT-1:0] stat
);

  for (genvar i = 0; i < NSTAT; i++) begin : g_bit
    logic set_i, w1c_i, hard_clr_i;
    assign set_i      = evt[i] && active;
    assign w1c_i      = wr_stat && wr_bits[i] && w1c_ok(i, mode);
    assign hard_clr_i = (stop_req_p && clr_on_stop(i, mode)) ||
                        (start_p && clr_on_start(i));
    always_ff @(posedge clk) begin
      if (!rst_n)          stat[i] <= 1'b0;
      else if (hard_clr_i) stat[i] <= 1'b0;
      else if (set_i)      stat[i] <= 1'b1;
      else if (w1c_i)      stat[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/raster_ctl_status.sv
module raster_ctl_status
  import raster_ctl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 4,
  parameter int IEN_LSB   = 8,
  parameter int MODE_LSB  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_frame_end,
  input  logic              evt_vsync,
  input  logic              evt_line,
  input  logic              evt_acb,
  input  logic              evt_pal_loaded,
  input  logic              evt_sync_lost,
  input  logic              evt_underflow,
  output logic              irq,
  output logic              lcd_on,
  output logic [1:0]        load_sel
);

  localparam int IEN_MSB = IEN_LSB + NSTAT - 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic             hit_ctrl, hit_stat;
  logic             ctrl_en;
  logic [NSTAT-1:0] ctrl_ien;
  logic [1:0]       ctrl_mode;
  logic             stopping, start_p, stop_req_p, stop_done_p;
  logic [NSTAT-1:0] evt_vec;
  logic [NSTAT-1:0] stat_q;
  logic [DATA_W-1:0] ctrl_word, stat_word;
  logic             unused_wdata;

  assign hit_ctrl = addr == A_CTRL;
  assign hit_stat = addr == A_STAT;

  assign unused_wdata = ^{wr_data[DATA_W-1:MODE_LSB+2],
                          wr_data[MODE_LSB-1:IEN_MSB+1],
                          wr_data[IEN_LSB-1:NSTAT]};

  raster_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_en && hit_ctrl),
    .wr_run   (wr_data[0]),
    .wr_ien   (wr_data[IEN_MSB:IEN_LSB]),
    .wr_mode  (wr_data[MODE_LSB+1:MODE_LSB]),
    .lcd_on   (lcd_on),
    .ctrl_en  (ctrl_en),
    .ctrl_ien (ctrl_ien),
    .ctrl_mode(ctrl_mode)
  );

  raster_run_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_en      (ctrl_en),
    .evt_frame_end(evt_frame_end),
    .lcd_on       (lcd_on),
    .stopping     (stopping),
    .start_p      (start_p),
    .stop_req_p   (stop_req_p),
    .stop_done_p  (stop_done_p)
  );

  assign evt_vec = {evt_underflow, evt_sync_lost, evt_pal_loaded,
                    evt_acb, evt_line, evt_vsync, stop_done_p};

  raster_stat_bank u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt_vec),
    .active    (lcd_on),
    .wr_stat   (wr_en && hit_stat),
    .wr_bits   (wr_data[NSTAT-1:0]),
    .mode      (ctrl_mode),
    .start_p   (start_p),
    .stop_req_p(stop_req_p),
    .stat      (stat_q)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[0] = ctrl_en;
    ctrl_word[IEN_MSB:IEN_LSB] = ctrl_ien;
    ctrl_word[MODE_LSB+1:MODE_LSB] = ctrl_mode;
    stat_word = '0;
    stat_word[NSTAT-1:0] = stat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= hit_ctrl ? ctrl_word : (hit_stat ? stat_word : '0);
  end

  assign irq      = irq_of(stat_q, ctrl_ien);
  assign load_sel = ctrl_mode;

endmodule

// File: rtl/raster_ctl_status_chk.sv
module raster_ctl_status_chk #(
  parameter int NSTAT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lcd_on,
  input logic             stopping,
  input logic             start_p,
  input logic             stop_req_p,
  input logic             evt_frame_end,
  input logic [NSTAT-1:0] stat,
  input logic             ien_done
);

  assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_on) |-> !stat[0]);

  assert_stop_at_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_on) |-> ($past(evt_frame_end) && stat[0]));

  assert_idle_events_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat[NSTAT-1:1] & ~$past(stat[NSTAT-1:1])) != '0) |-> $past(lcd_on));

  assert_errors_clear_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat[6:5]) & ~stat[6:5]) != 2'b00) |-> $past(stop_req_p));

  assert_done_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[0]) |-> $past(start_p));

  assert_done_en_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stopping) && stopping && $past(ien_done)) |-> ien_done);

endmodule

bind raster_ctl_status raster_ctl_status_chk #(.NSTAT(raster_ctl_pkg::NSTAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lcd_on       (lcd_on),
  .stopping     (stopping),
  .start_p      (start_p),
  .stop_req_p   (stop_req_p),
  .evt_frame_end(evt_frame_end),
  .stat         (stat_q),
  .ien_done     (ctrl_ien[0])
);

// File: tb/raster_ctl_status_tb.sv
`timescale 1ns/1ps
module raster_ctl_status_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        evt_frame_end = 0, evt_vsync = 0, evt_line = 0, evt_acb = 0;
  logic        evt_pal_loaded = 0, evt_sync_lost = 0, evt_underflow = 0;
  logic        irq, lcd_on;
  logic [1:0]  load_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4;

  always #2.5 clk = ~clk;

  raster_ctl_status u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .evt_frame_end(evt_frame_end),
    .evt_vsync(evt_vsync), .evt_line(evt_line), .evt_acb(evt_acb),
    .evt_pal_loaded(evt_pal_loaded), .evt_sync_lost(evt_sync_lost),
    .evt_underflow(evt_underflow), .irq(irq), .lcd_on(lcd_on), .load_sel(load_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // idx: 0 frame_end, 1 vsync, 2 line, 3 acb, 4 pal, 5 sync, 6 underflow
  task automatic pulse(input int idx);
    @(negedge clk);
    case (idx)
      0: evt_frame_end = 1;  1: evt_vsync = 1;  2: evt_line = 1;
      3: evt_acb = 1;        4: evt_pal_loaded = 1;
      5: evt_sync_lost = 1;  default: evt_underflow = 1;
    endcase
    @(negedge clk);
    {evt_frame_end, evt_vsync, evt_line, evt_acb, evt_pal_loaded,
     evt_sync_lost, evt_underflow} = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_STAT, v); check("R1 stat", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 lcd_on", {31'b0, lcd_on}, 0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd(A_CTRL, v); check("R2 unused bits read 0", v, 32'h0030_7F00);
    check("R2 load_sel", {30'b0, load_sel}, 32'd3);
    pulse(6);
    rd(A_STAT, v); check("R5 idle event ignored", v, 0);
    check("R10 irq idle", {31'b0, irq}, 0);
    wr(A_CTRL, 0);
    rd(9'd0, v);
    rd(4'h8, v); check("R12 unmapped reads 0", v, 0);
  endtask

  task automatic t_run_frame_mode();
    logic [31:0] v;
    wr(A_CTRL, 32'h0020_0001); cyc(1);
    check("R3 lcd_on rises", {31'b0, lcd_on}, 1);
    for (int i = 1; i <= 6; i++) pulse(i);
    rd(A_STAT, v); check("R5 all events", v, 32'h7E);
    wr(A_STAT, 32'h0E);
    rd(A_STAT, v); check("R6 w1c info bits", v, 32'h70);
    wr(A_STAT, 32'h71);
    rd(A_STAT, v); check("R7 R8 R9 write ignored", v, 32'h70);
    @(negedge clk); wr_en = 1; addr = A_STAT; wr_data = 32'h02; evt_vsync = 1;
    @(negedge clk); wr_en = 0; evt_vsync = 0;
    rd(A_STAT, v); check("R6 set beats clear", v, 32'h72);
    wr(A_STAT, 32'h02);
    rd(A_STAT, v); check("R6 vsync cleared", v, 32'h70);
    wr(A_CTRL, 32'h0020_4001);
    check("R10 irq underflow enabled", {31'b0, irq}, 1);
    wr(A_CTRL, 32'h0020_0201);
    check("R10 irq vsync enabled only", {31'b0, irq}, 0);
  endtask

  task automatic t_stop_frame_mode();
    logic [31:0] v;
    wr(A_CTRL, 32'h0020_0101);
    wr(A_CTRL, 32'h0020_0000);
    cyc(3);
    check("R4 still on before frame end", {31'b0, lcd_on}, 1);
    rd(A_STAT, v); check("R8 R7 cleared on stop", v, 0);
    rd(A_CTRL, v); check("R11 done enable kept", v, 32'h0020_0100);
    wr(A_CTRL, 32'h0020_0000);
    rd(A_CTRL, v); check("R11 second write kept", v, 32'h0020_0100);
    pulse(0);
    check("R4 lcd_on falls", {31'b0, lcd_on}, 0);
    check("R10 irq on done", {31'b0, irq}, 1);
    rd(A_STAT, v); check("R4 done set", v, 32'h01);
    wr(A_STAT, 32'h01);
    rd(A_STAT, v); check("R9 done held", v, 32'h01);
    wr(A_CTRL, 0);
    check("R10 irq masked", {31'b0, irq}, 0);
  endtask

  task automatic t_palette_mode();
    logic [31:0] v;
    wr(A_CTRL, 32'h0010_0001); cyc(1);
    rd(A_STAT, v); check("R3 R9 done cleared on start", v, 0);
    pulse(4);
    rd(A_STAT, v); check("R5 pal set", v, 32'h10);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); check("R7 pal w1c", v, 0);
    pulse(4); pulse(6);
    wr(A_STAT, 32'h40);
    rd(A_STAT, v); check("R8 uflow w1 ignored", v, 32'h50);
    wr(A_CTRL, 32'h0010_0000); cyc(2);
    rd(A_STAT, v); check("R7 R8 stop in pal mode", v, 32'h10);
    pulse(0);
    rd(A_STAT, v); check("R4 done after pal stop", v, 32'h11);
    pulse(2);
    rd(A_STAT, v); check("R5 idle line ignored", v, 32'h11);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    t_reset();
    t_ctrl_fields();
    t_run_frame_mode();
    t_stop_frame_mode();
    t_palette_mode();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule